// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs. A channel counts prescaled ticks from zero up to one less than its period value, then wraps. Its output is asserted while the count sits below the channel's duty value. Each channel has its own divider selection, duty value, period value, output polarity and run bit.

All settings live in a small bank of 32-bit registers, written through a single-cycle write strobe and read back combinationally. The live count of every channel can also be read, with two counts packed into each word. Duty, period and divider settings are held in a shadow copy. The running waveform picks up new values only when the count wraps, so a change in mid-period never produces a truncated pulse. Polarity and the run bit act at once.

Top module: `pwm_quad`

## Requirements
- R1: After reset every channel reads back run bit 0, divider code 7, polarity 0, duty 2 and period 4. All counters read 0 and all outputs are low.
- R2: Channel c owns byte addresses 16*c to 16*c+15. Offset +0x0 holds the run bit in bit 0. Offset +0x4 holds the divider code in bits 2:0 and the polarity in bit 3. Offset +0x8 holds duty in bits 15:0, and offset +0xC holds the period in bits 15:0. A write touches only the addressed field of the addressed channel.
- R3: Write data bits outside the defined fields are dropped, and those bits read back as 0. Writes to the counter words have no effect.
- R4: A running channel's counter steps by one on every prescaled tick and wraps from period-1 to 0. Address 0x40 returns channel 0's count in bits 15:0 and channel 1's count in bits 31:16. Address 0x44 returns channels 2 and 3 in the same way.
- R5: Divider codes 0 to 7 give one tick every 1, 4, 8, 16, 64, 256, 1024 and 4096 clocks respectively.
- R6: Before polarity, the output is active while count < duty. A duty of 0 is never active, and a duty at or above the period is always active.
- R7: Polarity 0 drives the active level high. Polarity 1 inverts the output.
- R8: A channel whose run bit is 0 holds its count and divider at 0, and its output sits at the inactive level (equal to the polarity bit).
- R9: A new duty, period or divider code written while a channel runs takes effect only at the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe, one write per asserted cycle |
| regAddr | input | ADDR_W | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| pwmOut | output | NUM_CH | One modulated output per channel |

## Verification
The hardest situation to reach is a settings change that lands in the middle of a running period. The waveform must keep the old duty or period until the wrap, then switch cleanly. The stimulus polls the packed counter word until the count reaches a known value. In that same cycle it writes a new duty, and later a new period. It then checks the count and output sample by sample against the old values up to the wrap and the new values after it. The slow divider settings are reached through windows of whole periods, which makes the high count and the number of counter steps independent of phase.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  localparam int CNT_W  = 16;
  localparam int PRE_W  = 3;
  localparam int DIV_W  = 12;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic             en;
    logic             pol;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] tc;
  } chanCfg_t;

  localparam chanCfg_t CFG_RESET = '{en: 1'b0, pol: 1'b0, pre: 3'd7,
                                     duty: 16'd2, tc: 16'd4};

  // last prescaler count value before a tick, per divider code
  function automatic logic [DIV_W-1:0] divLast(input logic [PRE_W-1:0] code);
    case (code)
      3'd0:    divLast = DIV_W'(0);
      3'd1:    divLast = DIV_W'(3);
      3'd2:    divLast = DIV_W'(7);
      3'd3:    divLast = DIV_W'(15);
      3'd4:    divLast = DIV_W'(63);
      3'd5:    divLast = DIV_W'(255);
      3'd6:    divLast = DIV_W'(1023);
      default: divLast = DIV_W'(4095);
    endcase
  endfunction

endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWr,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [DATA_W-1:0]                 regWrData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      chanCnt,
  output logic [DATA_W-1:0]                 regRdData,
  output chanCfg_t [NUM_CH-1:0]             cfg
);

  localparam int CFG_BYTES = NUM_CH * 16;
  localparam int PAIRS     = NUM_CH / 2;
  localparam int SEL_W     = ADDR_W - 4;

  logic [1:0]        wordSel;
  logic [SEL_W-1:0]  chanIdx;
  logic              inCfg;
  logic [ADDR_W-1:0] ctrOff;
  logic              unusedBits;

  assign wordSel    = regAddr[3:2];
  assign chanIdx    = regAddr[ADDR_W-1:4];
  assign inCfg      = regAddr < ADDR_W'(CFG_BYTES);
  assign ctrOff     = regAddr - ADDR_W'(CFG_BYTES);
  assign unusedBits = ^{regWrData[DATA_W-1:CNT_W], ctrOff[1:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfg[c] <= CFG_RESET;
      end else if (regWr && inCfg && chanIdx == SEL_W'(c)) begin
        case (wordSel)
          2'd0: cfg[c].en <= regWrData[0];
          2'd1: begin
            cfg[c].pre <= regWrData[PRE_W-1:0];
            cfg[c].pol <= regWrData[PRE_W];
          end
          2'd2: cfg[c].duty <= regWrData[CNT_W-1:0];
          default: cfg[c].tc <= regWrData[CNT_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (inCfg && chanIdx == SEL_W'(c)) begin
        case (wordSel)
          2'd0:    regRdData[0]         = cfg[c].en;
          2'd1:    regRdData[PRE_W:0]   = {cfg[c].pol, cfg[c].pre};
          2'd2:    regRdData[CNT_W-1:0] = cfg[c].duty;
          default: regRdData[CNT_W-1:0] = cfg[c].tc;
        endcase
      end
    end
    for (int p = 0; p < PAIRS; p++) begin
      if (!inCfg && ctrOff[ADDR_W-1:2] == (ADDR_W-2)'(p)) begin
        regRdData = {chanCnt[2*p+1], chanCnt[2*p]};
      end
    end
  end

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCfg_t         cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             pwmOut
);

  logic [DIV_W-1:0] preCnt;
  logic [PRE_W-1:0] shPre;
  logic [CNT_W-1:0] shDuty;
  logic [CNT_W-1:0] shTc;
  logic             tick;
  logic             lastStep;

  assign tick     = preCnt == divLast(shPre);
  assign lastStep = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, shTc};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
      shPre  <= CFG_RESET.pre;
      shDuty <= CFG_RESET.duty;
      shTc   <= CFG_RESET.tc;
    end else if (!cfg.en) begin
      preCnt <= '0;
      cnt    <= '0;
      shPre  <= cfg.pre;
      shDuty <= cfg.duty;
      shTc   <= cfg.tc;
    end else if (tick) begin
      preCnt <= '0;
      if (lastStep) begin
        cnt    <= '0;
        shPre  <= cfg.pre;
        shDuty <= cfg.duty;
        shTc   <= cfg.tc;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  assign pwmOut = (cfg.en && (cnt < shDuty)) ^ cfg.pol;

endmodule

// File: rtl/pwm_quad_datapath.sv
module pwm_quad_datapath
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chanCfg_t [NUM_CH-1:0]         cfg,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt,
  output logic [NUM_CH-1:0]             pwmOut
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_quad_chan chan_i (
      .clk    (clk),
      .rstN   (rstN),
      .cfg    (cfg[c]),
      .cnt    (chanCnt[c]),
      .pwmOut (pwmOut[c])
    );
  end

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  chanCfg_t [NUM_CH-1:0]         cfg;
  logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt;
  logic [NUM_CH-1:0]             chanEn;
  logic [NUM_CH-1:0]             chanPol;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flags
    assign chanEn[c]  = cfg[c].en;
    assign chanPol[c] = cfg[c].pol;
  end

  pwm_quad_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .chanCnt   (chanCnt),
    .regRdData (regRdData),
    .cfg       (cfg)
  );

  pwm_quad_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .chanCnt (chanCnt),
    .pwmOut  (pwmOut)
  );

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [31:0]                   regRdData,
  input logic [NUM_CH-1:0]             pwmOut,
  input logic [NUM_CH-1:0]             chanEn,
  input logic [NUM_CH-1:0]             chanPol,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt
);

  logic inCfg;
  assign inCfg = regAddr < ADDR_W'(NUM_CH * 16);

  // R1
  counters_cleared_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (chanCnt == '0));

  // R3
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCfg && regAddr[3:2] == 2'd1) |-> (regRdData[31:4] == '0));

  // R3
  enable_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCfg && regAddr[3:2] == 2'd0) |-> (regRdData[31:1] == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanEn[c] && $past(chanEn[c]) && chanCnt[c] != $past(chanCnt[c]))
      |-> (chanCnt[c] == $past(chanCnt[c]) + CNT_W'(1) || chanCnt[c] == '0));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
      !chanEn[c] |-> (pwmOut[c] == chanPol[c]));

    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(!chanEn[c]) |-> (chanCnt[c] == '0));
  end

endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .pwmOut    (pwmOut),
  .chanEn    (chanEn),
  .chanPol   (chanPol),
  .chanCnt   (chanCnt)
);

// File: tb/pwm_quad_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  pwmOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_quad dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pwmOut    (pwmOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic readCnt(input int ch, output int cnt);
    logic [31:0] w;
    rd(8'h40 + 8'((ch / 2) * 4), w);
    cnt = (ch % 2 == 1) ? int'(w[31:16]) : int'(w[15:0]);
  endtask

  task automatic setup(input int ch, input int pre, input bit pol, input int duty, input int tc);
    logic [7:0] b;
    b = 8'(ch * 16);
    wr(b, 32'h0);
    wr(b + 8'h4, {28'h0, pol, 3'(pre)});
    wr(b + 8'h8, 32'(duty));
    wr(b + 8'hC, 32'(tc));
    wr(b, 32'h1);
  endtask

  // samples n cycles; n must be whole periods of tc*div
  task automatic window(input string tag, input int ch, input int n, input int div,
                        input int tc, input int duty, input bit pol);
    int prev, cnt, highs, steps, outErr, rangeErr, active;
    highs = 0; steps = 0; outErr = 0; rangeErr = 0;
    readCnt(ch, prev);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      readCnt(ch, cnt);
      if (cnt != prev) steps++;
      if (cnt >= tc) rangeErr++;
      if (pwmOut[ch] !== (((cnt < duty) ? 1'b1 : 1'b0) ^ pol)) outErr++;
      if (pwmOut[ch] === 1'b1) highs++;
      prev = cnt;
    end
    active = ((duty < tc) ? duty : tc) * div * (n / (tc * div));
    chk({tag, " highs"}, 32'(highs), pol ? 32'(n - active) : 32'(active));
    chk({tag, " steps"}, 32'(steps), 32'(n / div));
    chk({tag, " out-vs-count"}, 32'(outErr), 32'h0);
    chk({tag, " count-range"}, 32'(rangeErr), 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 outputs", 32'(pwmOut), 32'h0);
    rd(8'h00, d); chk("R1 ch0 run", d, 32'h0);
    rd(8'h04, d); chk("R1 ch0 ctrl", d, 32'h7);
    rd(8'h08, d); chk("R1 ch0 duty", d, 32'h2);
    rd(8'h0C, d); chk("R1 ch0 period", d, 32'h4);
    rd(8'h34, d); chk("R1 ch3 ctrl", d, 32'h7);
    rd(8'h40, d); chk("R1 count word0", d, 32'h0);
    rd(8'h44, d); chk("R1 count word1", d, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(8'h28, 32'hABCD_1234);
    rd(8'h28, d); chk("R2 R3 ch2 duty", d, 32'h1234);
    wr(8'h24, 32'hFFFF_FFFD);
    rd(8'h24, d); chk("R2 R3 ch2 ctrl", d, 32'hD);
    wr(8'h20, 32'hFFFF_FFFE);
    rd(8'h20, d); chk("R3 ch2 run", d, 32'h0);
    wr(8'h2C, 32'h5555_0009);
    rd(8'h2C, d); chk("R2 R3 ch2 period", d, 32'h9);
    rd(8'h18, d); chk("R2 ch1 duty untouched", d, 32'h2);
    rd(8'h08, d); chk("R2 ch0 duty untouched", d, 32'h2);
    chk("R8 idle ch2 polarity level", 32'(pwmOut[2]), 32'h1);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, d); chk("R3 count word write ignored", d, 32'h0);
    wr(8'h24, 32'h7); wr(8'h28, 32'h2); wr(8'h2C, 32'h4);
    chk("R7 ch2 polarity cleared", 32'(pwmOut[2]), 32'h0);
  endtask

  task automatic t_wave;
    setup(0, 0, 1'b0, 2, 4);
    window("R4 R6 basic", 0, 16, 1, 4, 2, 1'b0);
    setup(0, 0, 1'b0, 0, 5);
    window("R6 duty zero", 0, 20, 1, 5, 0, 1'b0);
    setup(0, 0, 1'b0, 7, 5);
    window("R6 duty above period", 0, 20, 1, 5, 7, 1'b0);
    setup(0, 0, 1'b0, 5, 5);
    window("R6 duty equals period", 0, 20, 1, 5, 5, 1'b0);
    setup(0, 1, 1'b1, 1, 4);
    window("R7 inverted", 0, 32, 4, 4, 1, 1'b1);
  endtask

  task automatic t_shadow;
    int cnt;
    setup(0, 0, 1'b0, 2, 4);
    cnt = -1;
    while (cnt != 1) begin @(negedge clk); readCnt(0, cnt); end
    regWr = 1'b1; regAddr = 8'h08; regWrData = 32'h3;
    @(negedge clk); regWr = 1'b0;
    readCnt(0, cnt); chk("R9 count after duty write", 32'(cnt), 32'h2);
    chk("R9 old duty kept", 32'(pwmOut[0]), 32'h0);
    @(negedge clk); readCnt(0, cnt); chk("R9 old duty at 3", 32'(pwmOut[0]), 32'h0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    readCnt(0, cnt); chk("R9 count at 2", 32'(cnt), 32'h2);
    chk("R9 new duty after wrap", 32'(pwmOut[0]), 32'h1);
    while (cnt != 1) begin @(negedge clk); readCnt(0, cnt); end
    regWr = 1'b1; regAddr = 8'h0C; regWrData = 32'h6;
    @(negedge clk); regWr = 1'b0;
    @(negedge clk); @(negedge clk);
    readCnt(0, cnt); chk("R9 old period wrap", 32'(cnt), 32'h0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    readCnt(0, cnt); chk("R9 new period reaches 5", 32'(cnt), 32'h5);
  endtask

  task automatic t_disable;
    int cnt;
    wr(8'h00, 32'h0);
    chk("R8 disabled output", 32'(pwmOut[0]), 32'h0);
    @(negedge clk); readCnt(0, cnt);
    chk("R8 disabled count", 32'(cnt), 32'h0);
    wr(8'h04, 32'h8);
    chk("R8 R7 disabled inverted level", 32'(pwmOut[0]), 32'h1);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_prescale;
    int divs[7] = '{1, 4, 8, 16, 64, 256, 1024};
    logic [31:0] w;
    int lowBad;
    for (int k = 0; k < 7; k++) begin
      setup(1, k, 1'b0, 1, 2);
      window($sformatf("R5 code %0d", k), 1, 2 * divs[k], divs[k], 2, 1, 1'b0);
    end
    setup(1, 0, 1'b0, 1, 3);
    lowBad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rd(8'h40, w);
      if (w[15:0] != 16'h0 || w[31:16] > 16'd2) lowBad++;
    end
    chk("R4 packed halves", 32'(lowBad), 32'h0);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_default;
    wr(8'h30, 32'h1);
    window("R5 R1 default slowest", 3, 16384, 4096, 4, 2, 1'b0);
    wr(8'h30, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_wave();
    t_shadow();
    t_disable();
    t_prescale();
    t_default();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule